// File: doc/BRIEF.md
# Receive Retiming and Loss Gating

This block sits behind the line receiver's clock recovery. It takes a recovered receive clock and a dual-rail receive data pair (a positive rail and a negative rail), retimes the rails onto a chosen edge of that clock, and drives the receive data and clock outputs toward the framer. All logic runs on one fast system clock. The recovered clock arrives as a sampled level, and its edges are found by comparing it with its own registered copy.

Two configuration inputs set its behaviour. An edge select picks whether the rails are captured when the recovered clock rises or when it falls. A shutdown enable decides how a digital loss-of-signal alarm acts. When shutdown is enabled and the alarm is raised, both data outputs are parked at their inactive level. The output clock is then handed over to a free-running clock divided from the system clock. The handover uses a glitch-free switch that changes source only while both candidate clocks are low. When shutdown is disabled, the alarm has no effect on any output. An active-level select inverts both rails together, and it also sets the parked level.

Top module: `rxrt_retime_gate`

## Requirements
- R1: With `cfg_rise_edge` = 1, the rails are captured in the system cycle where `rx_clk_in` is 1 and its previous sampled value was 0, and they appear on the data outputs after that clock edge. No capture happens on a falling transition.
- R2: With `cfg_rise_edge` = 0, the rails are captured only where `rx_clk_in` is 0 and its previous sampled value was 1.
- R3: While `cfg_shutdown_en` and `dlos_alarm` are both 1, both data outputs are at the inactive level from the next system cycle on, whatever the input rails do.
- R4: While shutdown is in force and the clock switch has moved to the free-running source, `rx_clk_out` is a 50% clock with a period of 2*FREE_HALF system cycles (8 by default).
- R5: With `cfg_shutdown_en` = 0, `dlos_alarm` has no effect. Data follows R1/R2/R6, and `rx_clk_out` equals the `rx_clk_in` value sampled at the previous system edge.
- R6: Each data output equals the captured rail XOR `cfg_act_low`. The inactive level equals `cfg_act_low`: 0 for active-high and 1 for active-low.
- R7: The clock source changes only at an edge where both the registered recovered clock and the free-running clock are low. A shutdown request made while the recovered clock is held high therefore leaves `rx_clk_out` following the recovered clock. After the request ends, the output returns to following the recovered clock.
- R8: After reset, both data outputs and `rx_clk_out` are 0 (with `cfg_act_low` = 0), and the recovered clock is the selected source.
- R9: Capture continues while the outputs are parked. Rails captured during shutdown appear once the shutdown ends, with no new clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every other input |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rise_edge | input | 1 | 1: capture on a rising recovered-clock edge, 0: on a falling edge |
| cfg_shutdown_en | input | 1 | 1: the loss alarm parks the data and swaps the clock source |
| cfg_act_low | input | 1 | 1: outputs are active-low (inverted); also the parked level |
| dlos_alarm | input | 1 | Digital loss-of-signal alarm |
| rx_clk_in | input | 1 | Recovered receive clock, as a sampled level |
| rx_pos_in | input | 1 | Positive-rail receive data |
| rx_neg_in | input | 1 | Negative-rail receive data |
| rx_pos_out | output | 1 | Retimed positive-rail data |
| rx_neg_out | output | 1 | Retimed negative-rail data |
| rx_clk_out | output | 1 | Output receive clock (recovered or free-running) |

## Verification
A capture edge on the recovered clock can land in the same cycle that the loss gate engages or releases. Two results must hold together in that case: the outputs show the parked level, and the rail register still takes the new pair. The stimulus table provokes this by raising the gate and a rising recovered edge in one row, then dropping the gate with no edge in the next row. The captured pair must surface unchanged at that point. A second collision is a shutdown request that arrives while the recovered clock is high. It is judged by checking that the output clock keeps tracking the recovered level until that level falls, and only then shows the free-running period.

// File: rtl/rxrt_pkg.sv
package rxrt_pkg;

    // One sampled pair of receive rails.
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    // Which recovered-clock transition captures the rails.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } cap_edge_e;

    // Source currently feeding the output clock.
    typedef enum logic {
        SRC_RECOVERED = 1'b0,
        SRC_FREERUN   = 1'b1
    } clk_src_e;

    localparam rail_pair_t RAILS_ZERO = '{pos: 1'b0, neg: 1'b0};

    // Apply output polarity to both rails together.
    function automatic rail_pair_t apply_polarity(input rail_pair_t r, input logic act_low);
        rail_pair_t o;
        o.pos = r.pos ^ act_low;
        o.neg = r.neg ^ act_low;
        return o;
    endfunction

    // Parked pair: both rails at the inactive level for this polarity.
    function automatic rail_pair_t parked_pair(input logic act_low);
        rail_pair_t o;
        o.pos = act_low;
        o.neg = act_low;
        return o;
    endfunction

    // True when the sampled clock moved in the selected direction.
    function automatic logic edge_hit(input cap_edge_e sel, input logic now_lvl, input logic prev_lvl);
        logic hit;
        if (sel == EDGE_RISE) begin
            hit = now_lvl & ~prev_lvl;
        end else begin
            hit = ~now_lvl & prev_lvl;
        end
        return hit;
    endfunction

endpackage

// File: rtl/rxrt_capture.sv
module rxrt_capture
    import rxrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cap_edge_e  edge_sel,
    input  logic       clk_lvl,
    input  rail_pair_t rails_in,
    output logic       clk_lvl_q,
    output rail_pair_t rails_q
);

    logic take;

    always_comb begin
        take = edge_hit(edge_sel, clk_lvl, clk_lvl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_lvl_q <= 1'b0;
            rails_q   <= RAILS_ZERO;
        end else begin
            clk_lvl_q <= clk_lvl;
            if (take) begin
                rails_q <= rails_in;
            end
        end
    end

endmodule

// File: rtl/rxrt_freerun.sv
module rxrt_freerun #(
    parameter int unsigned FREE_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic fr_clk
);

    localparam int unsigned CNT_W = (FREE_HALF > 1) ? $clog2(FREE_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FREE_HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fr_clk <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            fr_clk <= ~fr_clk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rxrt_clk_switch.sv
module rxrt_clk_switch
    import rxrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     want_free,
    input  logic     rec_clk,
    input  logic     fr_clk,
    output clk_src_e src_q,
    output logic     clk_out
);

    logic both_low;

    always_comb begin
        both_low = ~rec_clk & ~fr_clk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_RECOVERED;
        end else if (both_low) begin
            src_q <= want_free ? SRC_FREERUN : SRC_RECOVERED;
        end
    end

    always_comb begin
        clk_out = (src_q == SRC_FREERUN) ? fr_clk : rec_clk;
    end

endmodule

// File: rtl/rxrt_retime_gate.sv
module rxrt_retime_gate
    import rxrt_pkg::*;
#(
    parameter int unsigned FREE_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_rise_edge,
    input  logic cfg_shutdown_en,
    input  logic cfg_act_low,
    input  logic dlos_alarm,
    input  logic rx_clk_in,
    input  logic rx_pos_in,
    input  logic rx_neg_in,
    output logic rx_pos_out,
    output logic rx_neg_out,
    output logic rx_clk_out
);

    rail_pair_t rails_in;
    rail_pair_t rails_q;
    rail_pair_t rails_drv;
    cap_edge_e  edge_sel;
    clk_src_e   src_q;
    logic       rec_clk_q;
    logic       fr_clk;
    logic       park_q;

    always_comb begin
        rails_in.pos = rx_pos_in;
        rails_in.neg = rx_neg_in;
        edge_sel     = cfg_rise_edge ? EDGE_RISE : EDGE_FALL;
    end

    rxrt_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .edge_sel  (edge_sel),
        .clk_lvl   (rx_clk_in),
        .rails_in  (rails_in),
        .clk_lvl_q (rec_clk_q),
        .rails_q   (rails_q)
    );

    // Shutdown request, registered so data and clock react from one cycle on.
    always_ff @(posedge clk) begin
        if (rst) begin
            park_q <= 1'b0;
        end else begin
            park_q <= cfg_shutdown_en & dlos_alarm;
        end
    end

    rxrt_freerun #(
        .FREE_HALF (FREE_HALF)
    ) u_freerun (
        .clk    (clk),
        .rst    (rst),
        .fr_clk (fr_clk)
    );

    rxrt_clk_switch u_switch (
        .clk       (clk),
        .rst       (rst),
        .want_free (park_q),
        .rec_clk   (rec_clk_q),
        .fr_clk    (fr_clk),
        .src_q     (src_q),
        .clk_out   (rx_clk_out)
    );

    always_comb begin
        rails_drv  = park_q ? parked_pair(cfg_act_low) : apply_polarity(rails_q, cfg_act_low);
        rx_pos_out = rails_drv.pos;
        rx_neg_out = rails_drv.neg;
    end

endmodule

// File: rtl/rxrt_retime_gate_chk.sv
module rxrt_retime_gate_chk
    import rxrt_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     cfg_rise_edge,
    input logic     cfg_shutdown_en,
    input logic     cfg_act_low,
    input logic     dlos_alarm,
    input logic     rx_clk_in,
    input logic     rx_pos_in,
    input logic     rx_neg_in,
    input logic     rx_pos_out,
    input logic     rx_neg_out,
    input logic     rec_clk_q,
    input logic     fr_clk,
    input clk_src_e src_q
);

    // R3: an active shutdown parks both rails at the polarity's idle level.
    a_r3_parked_level: assert property (@(posedge clk) disable iff (rst)
        (cfg_shutdown_en && dlos_alarm) |=>
            (rx_pos_out == cfg_act_low && rx_neg_out == cfg_act_low));

    // R1: a rising sampled edge captures the rails when rising mode is set.
    a_r1_rise_capture: assert property (@(posedge clk) disable iff (rst)
        (cfg_rise_edge && rx_clk_in && !rec_clk_q) |=>
            ($past(cfg_shutdown_en && dlos_alarm) ||
             (rx_pos_out == ($past(rx_pos_in) ^ cfg_act_low) &&
              rx_neg_out == ($past(rx_neg_in) ^ cfg_act_low))));

    // R2: a falling sampled edge captures the rails when falling mode is set.
    a_r2_fall_capture: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rise_edge && !rx_clk_in && rec_clk_q) |=>
            ($past(cfg_shutdown_en && dlos_alarm) ||
             (rx_pos_out == ($past(rx_pos_in) ^ cfg_act_low) &&
              rx_neg_out == ($past(rx_neg_in) ^ cfg_act_low))));

    // R7: the clock source moves only while both candidate clocks are low.
    a_r7_switch_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(src_q) |-> (!$past(rec_clk_q) && !$past(fr_clk)));

    // R5: with shutdown disabled the source stays on the recovered clock.
    a_r5_no_switch: assert property (@(posedge clk) disable iff (rst)
        (!cfg_shutdown_en && src_q == SRC_RECOVERED) |=> (src_q == SRC_RECOVERED));

endmodule

bind rxrt_retime_gate rxrt_retime_gate_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_rise_edge   (cfg_rise_edge),
    .cfg_shutdown_en (cfg_shutdown_en),
    .cfg_act_low     (cfg_act_low),
    .dlos_alarm      (dlos_alarm),
    .rx_clk_in       (rx_clk_in),
    .rx_pos_in       (rx_pos_in),
    .rx_neg_in       (rx_neg_in),
    .rx_pos_out      (rx_pos_out),
    .rx_neg_out      (rx_neg_out),
    .rec_clk_q       (rec_clk_q),
    .fr_clk          (fr_clk),
    .src_q           (src_q)
);

// File: tb/rxrt_retime_gate_bench.sv
module rxrt_retime_gate_bench;

    localparam int HALF = 4;
    localparam int NV   = 21;

    // Row: {req[3:0], rise, act_low, shut_en, alarm, clk_in, pos, neg, exp_pos, exp_neg}
    localparam logic [12:0] VEC [NV] = '{
        13'b0001_1_0_0_0_0_1_0_0_0, // R1 no edge yet
        13'b0001_1_0_0_0_1_1_0_1_0, // R1 rising capture
        13'b0001_1_0_0_0_1_0_1_1_0, // R1 level high, hold
        13'b0001_1_0_0_0_0_0_1_1_0, // R1 falling ignored
        13'b0001_1_0_0_0_1_0_1_0_1, // R1 rising capture
        13'b0010_0_0_0_0_1_1_1_0_1, // R2 no edge
        13'b0010_0_0_0_0_0_1_0_1_0, // R2 falling capture
        13'b0010_0_0_0_0_1_0_1_1_0, // R2 rising ignored
        13'b0010_0_0_0_0_0_0_1_0_1, // R2 falling capture
        13'b0110_0_1_0_0_0_0_0_1_0, // R6 inversion
        13'b0110_0_1_0_0_1_1_1_1_0, // R6 hold inverted
        13'b0110_0_1_0_0_0_1_1_0_0, // R6 capture inverted
        13'b0101_0_1_0_1_1_0_1_0_0, // R5 alarm, shutdown off
        13'b0101_0_1_0_1_0_0_1_1_0, // R5 capture under alarm
        13'b0011_0_1_1_1_1_1_0_1_1, // R3 parked high
        13'b0011_0_1_1_1_0_1_0_1_1, // R3 parked during capture
        13'b0011_0_0_1_1_1_1_0_0_0, // R3 parked low
        13'b0011_0_0_1_0_1_0_1_1_0, // R3 released
        13'b0010_0_0_1_0_0_0_1_0_1, // R2 capture again
        13'b1001_1_0_1_1_1_1_1_0_0, // R9 park and capture same cycle
        13'b1001_1_0_1_0_1_0_0_1_1  // R9 captured pair surfaces
    };

    logic clk = 1'b0;
    logic rst;
    logic cfg_rise_edge, cfg_shutdown_en, cfg_act_low, dlos_alarm;
    logic rx_clk_in, rx_pos_in, rx_neg_in;
    logic rx_pos_out, rx_neg_out, rx_clk_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rxrt_retime_gate #(.FREE_HALF(HALF)) u_rxrt_retime_gate (
        .clk             (clk),
        .rst             (rst),
        .cfg_rise_edge   (cfg_rise_edge),
        .cfg_shutdown_en (cfg_shutdown_en),
        .cfg_act_low     (cfg_act_low),
        .dlos_alarm      (dlos_alarm),
        .rx_clk_in       (rx_clk_in),
        .rx_pos_in       (rx_pos_in),
        .rx_neg_in       (rx_neg_in),
        .rx_pos_out      (rx_pos_out),
        .rx_neg_out      (rx_neg_out),
        .rx_clk_out      (rx_clk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on the falling edge, let the next rising edge act, sample 1 ns later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic re, input logic al, input logic se, input logic ls,
                         input logic ck, input logic p, input logic n);
        @(negedge clk);
        cfg_rise_edge   = re;
        cfg_act_low     = al;
        cfg_shutdown_en = se;
        dlos_alarm      = ls;
        rx_clk_in       = ck;
        rx_pos_in       = p;
        rx_neg_in       = n;
    endtask

    initial begin
        for (int w = 0; w < 20000; w++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int highs;
        int rises;
        logic prev;
        rst = 1'b1;
        cfg_rise_edge = 1'b1; cfg_act_low = 1'b0; cfg_shutdown_en = 1'b0;
        dlos_alarm = 1'b0; rx_clk_in = 1'b0; rx_pos_in = 1'b0; rx_neg_in = 1'b0;
        repeat (3) step();
        // R8: reset state
        check("R8 pos", rx_pos_out, 0);
        check("R8 neg", rx_neg_out, 0);
        check("R8 clk", rx_clk_out, 0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            drive(v[8], v[7], v[6], v[5], v[4], v[3], v[2]);
            step();
            check($sformatf("R%0d row %0d pos", v[12:9], i), rx_pos_out, v[1]);
            check($sformatf("R%0d row %0d neg", v[12:9], i), rx_neg_out, v[0]);
        end

        // Settle on the recovered source.
        drive(1, 0, 0, 0, 0, 0, 0);
        repeat (4 * HALF) step();

        // R5: alarm with shutdown off, clock follows one cycle late.
        for (int k = 0; k < 6; k++) begin
            logic c;
            c = (k == 0 || k == 1 || k == 3) ? 1'b1 : 1'b0;
            drive(1, 0, 0, 1, c, 0, 0);
            step();
            check("R5 clock pass", rx_clk_out, c);
        end

        // R7: request while the recovered clock is high, no switch.
        for (int k = 0; k < 3 * HALF; k++) begin
            drive(1, 0, 1, 1, 1, 1, 0);
            step();
            check("R7 hold recovered", rx_clk_out, 1);
        end

        // R4: recovered clock low, free-running clock takes over.
        drive(1, 0, 1, 1, 0, 1, 0);
        repeat (4 * HALF) step();
        check("R3 parked under freerun pos", rx_pos_out, 0);
        highs = 0; rises = 0; prev = rx_clk_out;
        for (int k = 0; k < 4 * HALF; k++) begin
            step();
            if (rx_clk_out) highs++;
            if (rx_clk_out && !prev) rises++;
            prev = rx_clk_out;
        end
        check("R4 high cycles", highs, 2 * HALF);
        check("R4 rising edges", rises, 2);

        // R7: request ends, output returns to the recovered clock.
        drive(1, 0, 1, 0, 0, 1, 0);
        repeat (4 * HALF) step();
        drive(1, 0, 1, 0, 1, 0, 0);
        step();
        check("R7 back on recovered hi", rx_clk_out, 1);
        check("R9 capture after release", rx_pos_out, 0);
        drive(1, 0, 1, 0, 0, 0, 0);
        step();
        check("R7 back on recovered lo", rx_clk_out, 0);

        // R8: reset mid-run clears the data path.
        drive(1, 0, 0, 0, 1, 1, 1);
        step();
        check("R1 pre-reset capture", rx_pos_out, 1);
        @(negedge clk);
        rst = 1'b1;
        step();
        check("R8 mid reset pos", rx_pos_out, 0);
        check("R8 mid reset neg", rx_neg_out, 0);
        check("R8 mid reset clk", rx_clk_out, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule